// File: doc/BRIEF.md
# Cascade Backplane Frame Synchronizer

This block steps one LCD driver through its backplane phases and keeps it frame-aligned with other drivers that share a single active-low synchronization line. The line is a wired-AND: every driver can pull it low through an open-drain output, and a pull-up holds it high otherwise. Each phase of `clk_i` selects one backplane. The multiplex mode sets how many backplanes are active: static gives one, 1:2 gives two, 1:3 gives three and 1:4 gives four.

A driver pulls the line low for the single phase in which its last active backplane starts. It treats the line as an input during every other phase. The sensed level passes through a synchronizer of `SYNC_STAGES` flops. A pull-down by another driver shows up as a low level that the driver's own output did not cause. When the driver sees such a level, it reloads its phase counter with the phase that the asserting driver will have reached by then. The first driver to assert therefore sets the frame for the whole cascade. Drivers that leave reset together start aligned and need no line activity.

The analog backplane levels, the bias generation and the segment data path are handled elsewhere.

Top module: `bp_frame_sync`

## Requirements
- R1: While reset is low, and at the first clock after it is released, `bp_idx_o` is 0 and `sync_pull_o` is 0.
- R2: `mux_mode_i` encodes the active backplane count N as code+1: 0 is static (N=1), 1 is 1:2, 2 is 1:3 and 3 is 1:4. While the line is quiet and the mode is unchanged, `bp_idx_o` steps through 0, 1, …, N-1 and then wraps to 0, one step per clock.
- R3: `sync_pull_o` is 1 exactly when `bp_idx_o` equals N-1 for the mode in effect. In static mode it is therefore 1 on every phase.
- R4: The line level passes through `SYNC_STAGES` flops before it is used. Suppose the line is low in clock cycle t and the driver's own pull was 0 in cycle t. Then in cycle t+SYNC_STAGES+1 `bp_idx_o` equals SYNC_STAGES mod N, which is the phase that a driver that pulled in cycle t holds in that cycle.
- R5: A low line level that occurs in a cycle in which the driver's own pull was 1 does not disturb the sequence.
- R6: When `mux_mode_i` differs from the mode in effect, the next phase is backplane 0 under the new mode. This restart takes precedence over a realignment.
- R7: Once the driver is aligned with another driver that runs the same mode, both pull in the same cycles and their phases stay equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock; one cycle per backplane phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_mode_i | input | 2 | Multiplex mode code (0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4) |
| sync_line_i | input | 1 | Sensed level of the shared synchronization line |
| bp_idx_o | output | 2 | Index of the active backplane |
| sync_pull_o | output | 1 | 1 enables the open-drain pull-down on the shared line |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. With three stages the realignment value becomes 3 in 1:4 mode, which is the last backplane, so the driver pulls again straight after realigning. The same value becomes 0 in 1:3 mode and 1 in 1:2 mode. A behavioural second driver runs deliberately out of phase in 1:4 and in 1:2 modes and forces a realignment. Aligned operation then makes the driver's own pulls coincide with foreign ones, which exercises the echo mask.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned BP_W = 2;

    typedef logic [BP_W-1:0] bp_idx_t;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_DUAL   = 2'd1,
        MUX_TRI    = 2'd2,
        MUX_QUAD   = 2'd3
    } mux_mode_e;

    typedef struct packed {
        mux_mode_e mode;
        bp_idx_t   phase;
        logic      pull;
    } frame_state_t;

    // index of the final active backplane for a mode
    function automatic bp_idx_t last_bp(input logic [1:0] m);
        return bp_idx_t'(m);
    endfunction

    // phase a foreign asserter holds once its pulse has crossed the synchronizer
    function automatic bp_idx_t realign_phase(input logic [1:0] m, input int unsigned stages);
        int unsigned n;
        n = int'(m) + 1;
        return bp_idx_t'(stages % n);
    endfunction
endpackage

// File: rtl/bfs_shift.sv
module bfs_shift #(
    parameter int unsigned DEPTH     = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [DEPTH-1:0] stage_d;
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                stage_d = d_i;
            end
        end else begin : g_chain
            always_comb begin
                stage_d = {stage_q[DEPTH-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= {DEPTH{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/bfs_phase_ctrl.sv
module bfs_phase_ctrl
    import bfs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  mux_mode_e mode_i,
    input  logic      line_sync_i,
    input  logic      echo_i,
    output bp_idx_t   phase_o,
    output logic      pull_o
);
    timeunit 1ns;
    timeprecision 100ps;

    frame_state_t st_d;
    frame_state_t st_q;
    logic         mode_chg;
    logic         foreign;

    always_comb begin
        st_d     = st_q;
        mode_chg = (mode_i != st_q.mode);
        foreign  = !line_sync_i && !echo_i;

        if (mode_chg) begin
            st_d.mode  = mode_i;
            st_d.phase = '0;
        end else if (foreign) begin
            st_d.phase = realign_phase(st_q.mode, SYNC_STAGES);
        end else if (st_q.phase >= last_bp(st_q.mode)) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + bp_idx_t'(1);
        end

        st_d.pull = (st_d.phase == last_bp(st_d.mode));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MUX_STATIC, phase: '0, pull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign pull_o  = st_q.pull;
endmodule

// File: rtl/bp_frame_sync.sv
module bp_frame_sync
    import bfs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mux_mode_i,
    input  logic       sync_line_i,
    output logic [1:0] bp_idx_o,
    output logic       sync_pull_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic line_sync_w;
    logic echo_w;

    // sensed line, idles high
    bfs_shift #(.DEPTH(SYNC_STAGES), .RESET_VAL(1'b1)) i_line_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sync_line_i),
        .q_o   (line_sync_w)
    );

    // own pull delayed to match the synchronizer, masks self-echo
    bfs_shift #(.DEPTH(SYNC_STAGES), .RESET_VAL(1'b0)) i_echo (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sync_pull_o),
        .q_o   (echo_w)
    );

    bfs_phase_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mux_mode_e'(mux_mode_i)),
        .line_sync_i(line_sync_w),
        .echo_i     (echo_w),
        .phase_o    (bp_idx_o),
        .pull_o     (sync_pull_o)
    );
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker
    import bfs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mux_mode_i,
    input logic [1:0] bp_idx_o,
    input logic       sync_pull_o,
    input logic       line_sync,
    input logic       echo
);
    timeunit 1ns;
    timeprecision 100ps;

    p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (bp_idx_o == 2'd0 && !sync_pull_o));

    p_index_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (bp_idx_o <= $past(mux_mode_i)));

    p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && line_sync && mux_mode_i == $past(mux_mode_i)
         && bp_idx_o < mux_mode_i) |=> (bp_idx_o == 2'($past(bp_idx_o) + 2'd1)));

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && line_sync && mux_mode_i == $past(mux_mode_i)
         && bp_idx_o == mux_mode_i) |=> (bp_idx_o == 2'd0));

    p_pull_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (sync_pull_o == (bp_idx_o == $past(mux_mode_i))));

    p_realign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !line_sync && !echo && mux_mode_i == $past(mux_mode_i))
        |=> (bp_idx_o == realign_phase($past(mux_mode_i), SYNC_STAGES)));

    p_echo_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !line_sync && echo && mux_mode_i == $past(mux_mode_i)
         && bp_idx_o < mux_mode_i) |=> (bp_idx_o == 2'($past(bp_idx_o) + 2'd1)));

    p_mode_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && mux_mode_i != $past(mux_mode_i)) |=> (bp_idx_o == 2'd0));
endmodule

bind bp_frame_sync bfs_checker #(.SYNC_STAGES(SYNC_STAGES)) i_bfs_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mux_mode_i (mux_mode_i),
    .bp_idx_o   (bp_idx_o),
    .sync_pull_o(sync_pull_o),
    .line_sync  (line_sync_w),
    .echo       (echo_w)
);

// File: tb/test_bp_frame_sync.sv
module test_bp_frame_sync;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TB_STAGES = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       ext_en;
    logic [1:0] bp;
    logic       pull;
    int         ext_n = 4;
    int         ext_phase = 0;
    int         total = 0;
    int         bad = 0;
    string      cur_req = "R1";

    wire ext_pull  = ext_en && (ext_phase == ext_n - 1);
    wire sync_line = !(pull | ext_pull);

    always #2.5 clk = ~clk;

    bp_frame_sync #(.SYNC_STAGES(TB_STAGES)) i_bp_frame_sync (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mux_mode_i (mode),
        .sync_line_i(sync_line),
        .bp_idx_o   (bp),
        .sync_pull_o(pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: queues hold line and own pull history
    int m_phase, m_pull, m_mode;
    bit q_line[$];
    bit q_pull[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pull = 0; m_mode = 0;
            q_line.delete(); q_pull.delete();
            for (int i = 0; i < TB_STAGES; i++) begin
                q_line.push_back(1'b1);
                q_pull.push_back(1'b0);
            end
        end else begin
            bit fl, fp;
            int n;
            q_line.push_back(sync_line);
            q_pull.push_back(m_pull != 0);
            fl = q_line.pop_front();
            fp = q_pull.pop_front();
            n = m_mode + 1;
            if (int'(mode) != m_mode) begin
                m_mode = int'(mode);
                m_phase = 0;
            end else if (!fl && !fp) begin
                m_phase = TB_STAGES % n;
            end else begin
                m_phase = (m_phase + 1) % n;
            end
            m_pull = (m_phase == m_mode) ? 1 : 0;
        end
        ext_phase = (ext_phase + 1) % ext_n;
    end

    always @(negedge clk) begin
        chk(bp === 2'(m_phase), {cur_req, " phase"}, int'(bp), m_phase);
        chk(pull === (m_pull != 0), {cur_req, " pull"}, int'(pull), m_pull);
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align_run(input logic [1:0] md, input int n);
        int pulls;
        #1 mode = md; ext_n = n;
        wait_cycles(3);
        #1 ext_phase = (int'(bp) + 1) % n;
        ext_en = 1'b1;
        cur_req = "R4";
        wait_cycles(2 * n + TB_STAGES + 3);
        chk(int'(bp) == ext_phase, "R4 realigned phase", int'(bp), ext_phase);
        cur_req = "R7";
        pulls = 0;
        for (int i = 0; i < 16; i++) begin
            wait_cycles(1);
            chk(int'(bp) == ext_phase, "R7 phase held", int'(bp), ext_phase);
            chk(pull == ext_pull, "R5 echo coincides", int'(pull), int'(ext_pull));
            if (pull) pulls++;
        end
        chk(pulls == 16 / n, "R7 pull count", pulls, 16 / n);
        #1 ext_en = 1'b0;
    endtask

    initial begin
        int pulls;
        rst_n = 1'b0; mode = 2'd3; ext_en = 1'b0;
        wait_cycles(3);
        chk(bp == 2'd0 && !pull, "R1 reset state", int'({bp, pull}), 0);
        #1 rst_n = 1'b1;
        wait_cycles(1);
        chk(bp == 2'd0 && !pull, "R1 after release", int'({bp, pull}), 0);

        cur_req = "R2";
        wait_cycles(4);
        pulls = 0;
        for (int i = 0; i < 8; i++) begin
            wait_cycles(1);
            chk(pull == (bp == 2'd3), "R3 pull on last", int'(pull), int'(bp == 2'd3));
            if (pull) pulls++;
        end
        chk(pulls == 2, "R5 own echo ignored", pulls, 2);

        #1 mode = 2'd1; cur_req = "R6";
        wait_cycles(1);
        chk(bp == 2'd0, "R6 restart 1:2", int'(bp), 0);
        cur_req = "R2";
        wait_cycles(6);
        #1 mode = 2'd2; cur_req = "R6";
        wait_cycles(1);
        chk(bp == 2'd0, "R6 restart 1:3", int'(bp), 0);
        cur_req = "R2";
        wait_cycles(8);
        #1 mode = 2'd0; cur_req = "R3";
        for (int i = 0; i < 6; i++) begin
            wait_cycles(1);
            chk(bp == 2'd0 && pull, "R3 static pulls", int'({bp, pull}), 1);
        end

        align_run(2'd3, 4);
        align_run(2'd1, 2);
        align_run(2'd2, 3);

        cur_req = "R2";
        wait_cycles(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule